// File: doc/BRIEF.md
# Temperature ADC conversion sequencer

This block owns the 16-bit control word of an auxiliary temperature converter and paces its conversions. The control word is written and read over a simple parallel port. From it the block decodes the converter's input-pair select, amplifier gain, reference choice and result resolution. A write that sets the start bit runs one conversion. A continuous bit makes conversions follow one another with no gap.

Conversion length is counted in ticks of a one-millisecond strobe. The length depends on the resolution code together with the internal-temperature-mode bit and the internal-reference bit. A double-speed bit shortens one case only. When a conversion ends, the block emits a one-cycle done pulse. It latches the modelled converter data word, sign-extended from the width that the active mode gives, and clears the start bit.

Top module: `tadc_seq`

## Requirements
- R1: After reset the control word reads 0, done is low, result is 0, ref_sel is 0 and gain is 1.
- R2: The control word holds, from bit 15 down: two reserved bits, double-speed (13), start (12), current-source enable (11), continuous (10), internal temperature mode (9), internal reference (8), reference code (7:6), mux code (5:4), gain code (3:2) and resolution code (1:0). Writes store it and rd_data returns it, except bits 15:14, which always read 0.
- R3: A write with bit 12 set starts a conversion. Bit 12 reads 1 while that conversion runs and reads 0 from the cycle done rises. done is high for exactly one cycle.
- R4: While bit 10 is 1, conversions run back to back. With N ticks per conversion and a tick every cycle, successive done pulses are N cycles apart. After bit 10 is cleared, the running conversion ends and no more follow.
- R5: With bit 9 set, resolution codes 0/1/2/3 take 3/6/12/24 ticks and give 9/10/11/12 magnitude bits on res_bits.
- R6: With bits 9 and 8 clear, codes 0/1/2/3 take 6/24/50/100 ticks and give 11/13/14/15 magnitude bits.
- R7: With bit 9 clear and bit 8 set, codes 0/1/2/3 take 8/32/64/128 ticks, with the same bit counts as R6.
- R8: Bit 13 cuts the conversion to 3 ticks only when the resolution code is 0 and bits 9 and 8 are clear. In every other case it has no effect.
- R9: ref_sel is 4 (internal) when bit 8 is set. Otherwise it equals the reference code: 0 primary reference, 1 excitation, 2 supply, 3 reserved.
- R10: mux_sel equals the mux code and gain equals 1 shifted left by the gain code.
- R11: A start write during a running conversion aborts it. No done pulse is issued for the aborted conversion, and the new conversion takes its full tick count from that write.
- R12: At done, result is conv_data sign-extended from bit b, where b is the magnitude bit count of the finished conversion.
- R13: Only cycles with ms_tick high advance a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ms_tick | input | 1 | One-millisecond strobe |
| wr_en | input | 1 | Control word write enable |
| wr_data | input | 16 | Control word write data |
| rd_data | output | 16 | Control word readback |
| conv_data | input | 16 | Modelled converter data word |
| mux_sel | output | 2 | Input pair select |
| gain | output | 4 | Amplifier gain (1, 2, 4, 8) |
| ref_sel | output | 3 | Reference select |
| res_bits | output | 4 | Magnitude bits of the current mode |
| busy | output | 1 | Conversion running |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | Sign-extended result |

## Verification
The bench sweeps every combination of resolution code, mode bit, reference bit and double-speed bit, and counts the cycles from the start write to done. A design that applied double speed outside its one case, or picked the wrong timing column, would be off by a full tick count. Each sweep point feeds a different data word, so a sign extension taken from the wrong bit would corrupt the upper result bits. Restart, continuous and gated-tick runs target a design that leaks a done pulse from an aborted conversion, keeps running after continuous mode is cleared, or counts cycles instead of ticks.

// File: rtl/tadc_pkg.sv
package tadc_pkg;
    typedef struct packed {
        logic [1:0] rsvd;
        logic       fast2x;
        logic       start;
        logic       isrc_en;
        logic       cont;
        logic       int_temp;
        logic       int_ref;
        logic [1:0] ref_code;
        logic [1:0] mux_code;
        logic [1:0] gain_code;
        logic [1:0] res_code;
    } tadc_cfg_t;

    typedef enum logic [2:0] {
        REF_PRIMARY  = 3'd0,
        REF_EXCITE   = 3'd1,
        REF_SUPPLY   = 3'd2,
        REF_RESERVED = 3'd3,
        REF_INTERNAL = 3'd4
    } tadc_ref_e;
endpackage

// File: rtl/tadc_decode.sv
module tadc_decode
    import tadc_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int BITS_W = 4
) (
    input  tadc_cfg_t         cfg,
    output logic [1:0]        mux_sel,
    output logic [3:0]        gain,
    output tadc_ref_e         ref_sel,
    output logic [BITS_W-1:0] mag_bits,
    output logic [CNT_W-1:0]  ticks
);
    always_comb begin
        mux_sel = cfg.mux_code;
        gain    = 4'd1 << cfg.gain_code;
        if (cfg.int_ref) ref_sel = REF_INTERNAL;
        else             ref_sel = tadc_ref_e'({1'b0, cfg.ref_code});

        if (cfg.int_temp) begin
            mag_bits = BITS_W'(9) + BITS_W'(cfg.res_code);
            ticks    = CNT_W'(3) << cfg.res_code;
        end else begin
            case (cfg.res_code)
                2'd0:    mag_bits = BITS_W'(11);
                2'd1:    mag_bits = BITS_W'(13);
                2'd2:    mag_bits = BITS_W'(14);
                default: mag_bits = BITS_W'(15);
            endcase
            if (cfg.int_ref) begin
                case (cfg.res_code)
                    2'd0:    ticks = CNT_W'(8);
                    2'd1:    ticks = CNT_W'(32);
                    2'd2:    ticks = CNT_W'(64);
                    default: ticks = CNT_W'(128);
                endcase
            end else begin
                case (cfg.res_code)
                    2'd0:    ticks = cfg.fast2x ? CNT_W'(3) : CNT_W'(6);
                    2'd1:    ticks = CNT_W'(24);
                    2'd2:    ticks = CNT_W'(50);
                    default: ticks = CNT_W'(100);
                endcase
            end
        end
    end
endmodule

// File: rtl/tadc_conv_seq.sv
module tadc_conv_seq #(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8,
    parameter int BITS_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_start,
    input  logic              cen_next,
    input  logic [CNT_W-1:0]  ticks_next,
    input  logic [BITS_W-1:0] bits_next,
    input  logic [DATA_W-1:0] conv_data,
    output logic              finish,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] result
);
    typedef struct packed {
        logic              busy;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  target;
        logic [BITS_W-1:0] bits;
        logic              done;
        logic [DATA_W-1:0] result;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic    start;
    logic [DATA_W-1:0] ext_d;

    always_comb begin
        finish = st_q.busy && tick && !wr_start &&
                 (st_q.cnt == st_q.target - CNT_W'(1));
        start  = wr_start || (cen_next && (!st_q.busy || finish));
        for (int i = 0; i < DATA_W; i++) begin
            ext_d[i] = (i <= int'(st_q.bits)) ? conv_data[i] : conv_data[st_q.bits];
        end

        st_d      = st_q;
        st_d.done = finish;
        if (finish) begin
            st_d.result = ext_d;
            st_d.busy   = 1'b0;
        end else if (st_q.busy && tick) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
        if (start) begin
            st_d.busy   = 1'b1;
            st_d.cnt    = '0;
            st_d.target = ticks_next;
            st_d.bits   = bits_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.target <= CNT_W'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assign busy   = st_q.busy;
    assign done   = st_q.done;
    assign result = st_q.result;

    // R3
    done_one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done);
    // R13
    cnt_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (st_q.cnt < st_q.target));
    // R13
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !tick && !wr_start && !st_d.done) |=> $stable(st_q.cnt));
    // R11
    abort_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |=> !st_q.done);
endmodule

// File: rtl/tadc_seq.sv
module tadc_seq
    import tadc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ms_tick,
    input  logic              wr_en,
    input  logic [15:0]       wr_data,
    output logic [15:0]       rd_data,
    input  logic [DATA_W-1:0] conv_data,
    output logic [1:0]        mux_sel,
    output logic [3:0]        gain,
    output logic [2:0]        ref_sel,
    output logic [3:0]        res_bits,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] result
);
    localparam int BITS_W = 4;

    tadc_cfg_t cfg_q, cfg_w, cfg_d;
    logic      wr_start, cen_next, finish;
    tadc_ref_e ref_now, ref_nx_unused;
    logic [1:0] mux_nx_unused;
    logic [3:0] gain_nx_unused;
    logic [BITS_W-1:0] bits_nx, bits_now;
    logic [CNT_W-1:0]  ticks_nx, ticks_now_unused;

    always_comb begin
        cfg_w = cfg_q;
        if (wr_en) begin
            cfg_w      = tadc_cfg_t'(wr_data);
            cfg_w.rsvd = 2'b00;
        end
        wr_start = wr_en && wr_data[12];
        cen_next = cfg_w.cont;
        cfg_d    = cfg_w;
        if (finish) cfg_d.start = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    tadc_decode #(.CNT_W(CNT_W), .BITS_W(BITS_W)) dec_now_i (
        .cfg(cfg_q), .mux_sel(mux_sel), .gain(gain), .ref_sel(ref_now),
        .mag_bits(bits_now), .ticks(ticks_now_unused)
    );

    tadc_decode #(.CNT_W(CNT_W), .BITS_W(BITS_W)) dec_next_i (
        .cfg(cfg_w), .mux_sel(mux_nx_unused), .gain(gain_nx_unused),
        .ref_sel(ref_nx_unused), .mag_bits(bits_nx), .ticks(ticks_nx)
    );

    tadc_conv_seq #(.DATA_W(DATA_W), .CNT_W(CNT_W), .BITS_W(BITS_W)) seq_i (
        .clk(clk), .rst_n(rst_n), .tick(ms_tick), .wr_start(wr_start),
        .cen_next(cen_next), .ticks_next(ticks_nx), .bits_next(bits_nx),
        .conv_data(conv_data), .finish(finish), .busy(busy), .done(done),
        .result(result)
    );

    assign rd_data  = 16'(cfg_q);
    assign ref_sel  = ref_now;
    assign res_bits = bits_now;

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[15:14] == 2'b00);
    // R3
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !rd_data[12]);
    // R9
    ref_internal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[8] |-> (ref_sel == 3'd4));
    // R3
    start_means_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[12] |-> busy);
endmodule

// File: tb/tadc_seq_tb_top.sv
`timescale 1ns/1ps
module tadc_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ms_tick = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] conv_data = '0;
    logic [15:0] rd_data, result;
    logic [1:0]  mux_sel;
    logic [3:0]  gain, res_bits;
    logic [2:0]  ref_sel;
    logic        busy, done;

    int checks = 0;
    int errors = 0;
    int tick_div = 1;
    int tcnt = 0;

    always #2.5 clk = ~clk;

    tadc_seq dut_i (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .conv_data(conv_data),
        .mux_sel(mux_sel), .gain(gain), .ref_sel(ref_sel), .res_bits(res_bits),
        .busy(busy), .done(done), .result(result)
    );

    always @(negedge clk) begin
        if (tick_div <= 1) ms_tick = 1'b1;
        else begin
            tcnt    = (tcnt + 1) % tick_div;
            ms_tick = (tcnt == 0);
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // counts negedges after the write edge until done is seen
    task automatic wait_done(input int limit, output int n, output logic st_seen);
        n = 0;
        st_seen = 1'b1;
        while (n < limit) begin
            @(negedge clk);
            n++;
            if (done) break;
            if (!rd_data[12] && wr_data[12]) st_seen = 1'b0;
        end
    endtask

    function automatic int exp_ticks(bit ten, bit aren, bit x2, int r);
        if (ten) return 3 * (1 << r);
        if (aren) return (r == 0) ? 8 : (r == 1) ? 32 : (r == 2) ? 64 : 128;
        if (r == 0) return x2 ? 3 : 6;
        return (r == 1) ? 24 : (r == 2) ? 50 : 100;
    endfunction

    function automatic int exp_bits(bit ten, int r);
        if (ten) return 9 + r;
        return (r == 0) ? 11 : (r == 1) ? 13 : (r == 2) ? 14 : 15;
    endfunction

    function automatic logic [15:0] sext(logic [15:0] d, int b);
        logic signed [15:0] t;
        t = $signed(d << (15 - b));
        return 16'(t >>> (15 - b));
    endfunction

    initial begin
        int n, cnt_d;
        logic seen;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 rd_data", 32'(rd_data), 0);
        chk("R1 done", 32'(done), 0);
        chk("R1 result", 32'(result), 0);
        chk("R1 ref_sel", 32'(ref_sel), 0);
        chk("R1 gain", 32'(gain), 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reserved bits and plain readback
        do_write(16'hC000 | 16'h0AFF & 16'hF3FF);
        chk("R2 readback", 32'(rd_data), 32'(16'h02FF));
        do_write(16'h0000);

        // R5 R6 R7 R8 R9 R10 R12 sweep
        for (int idx = 0; idx < 32; idx++) begin
            bit ten, aren, x2;
            int r, rv, m, g;
            logic [15:0] cfg;
            r = idx % 4; x2 = idx[2]; aren = idx[3]; ten = idx[4];
            rv = idx % 3; m = (idx / 2) % 4; g = (idx / 3) % 4;
            cfg = {2'b00, x2, 1'b1, 1'b0, 1'b0, ten, aren, 2'(rv), 2'(m), 2'(g), 2'(r)};
            conv_data = 16'h1357 * 16'(idx + 1) ^ 16'h8421;
            do_write(cfg);
            chk("R10 mux", 32'(mux_sel), 32'(m));
            chk("R10 gain", 32'(gain), 32'(1 << g));
            chk("R9 ref", 32'(ref_sel), aren ? 32'd4 : 32'(rv));
            chk("R5 R6 bits", 32'(res_bits), 32'(exp_bits(ten, r)));
            wait_done(300, n, seen);
            chk("R5 R6 R7 R8 ticks", 32'(n), 32'(exp_ticks(ten, aren, x2, r)));
            chk("R3 start reads 1 while busy", 32'(seen), 1);
            chk("R3 start self-clear", 32'(rd_data[12]), 0);
            chk("R12 result", 32'(result), 32'(sext(conv_data, exp_bits(ten, r))));
            @(negedge clk);
            chk("R3 done one cycle", 32'(done), 0);
        end

        // R11 abort
        do_write(16'h1001);
        cnt_d = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (done) cnt_d++;
        end
        do_write(16'h1001);
        wait_done(300, n, seen);
        chk("R11 no done for aborted", 32'(cnt_d), 0);
        chk("R11 restart length", 32'(n), 24);

        // R4 continuous
        do_write(16'h0600);
        wait_done(100, n, seen);
        chk("R4 first", 32'(n), 3);
        wait_done(100, n, seen);
        chk("R4 spacing", 32'(n), 3);
        wait_done(100, n, seen);
        chk("R4 spacing again", 32'(n), 3);
        do_write(16'h0200);
        repeat (10) @(negedge clk);
        cnt_d = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (done || busy) cnt_d++;
        end
        chk("R4 stops after clear", 32'(cnt_d), 0);

        // R13 gated ticks
        tick_div = 3;
        do_write(16'h1200);
        wait_done(100, n, seen);
        chk("R13 tick gating", 32'((n >= 7) && (n <= 9)), 1);
        tick_div = 1;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5ns * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule